// File: doc/BRIEF.md
# Atomic GPIO Data Port

This block is the data side of a 32-pin general-purpose I/O port. It sits on a simple memory-mapped register bus. It holds a latch for the output value and a direction mask, and it drives the pad output values and the output enables from them. It also brings the input pins into the clock domain through a synchronizer, so software can read their levels.

Software can load the output latch as a whole word. It can also change only chosen bits by writing a bitmask to one of three write-only alias addresses, which set, clear or invert those bits. Several pins can therefore change in one bus write, without a read-modify-write and without disturbing the other pins. Pin multiplexing, pulls, glitch filtering and interrupts belong to a separate block.

Register writes take effect at the rising clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`. The address is a byte offset, and bits [1:0] are ignored.

Top module: `gpio_data_port`

## Requirements
- R1: While reset is asserted, and after it is released, the output latch and the direction mask are all zeros, so `pad_oe` and `pad_out` are 0 on every pin.
- R2: A write to offset 0x00 loads the output latch with `bus_wdata`. A read of offset 0x00 returns the latch.
- R3: A write to offset 0x04 sets to 1 every latch bit whose `bus_wdata` bit is 1 and leaves the other bits unchanged.
- R4: A write to offset 0x08 clears to 0 every latch bit whose `bus_wdata` bit is 1 and leaves the other bits unchanged.
- R5: A write to offset 0x0C inverts every latch bit whose `bus_wdata` bit is 1 and leaves the other bits unchanged.
- R6: A read of offset 0x10 returns `pad_in` as it was sampled two rising edges earlier. After only one edge, the old level is still returned.
- R7: A write to offset 0x14 loads the direction mask, and a read of 0x14 returns it. Bit 1 makes the pin an output and bit 0 an input. `pad_oe` equals the mask.
- R8: `pad_out` equals the latch bit where the direction bit is 1, and 0 where it is 0.
- R9: Reads of offsets 0x04, 0x08, 0x0C, 0x18 and 0x1C return 0. Writes to 0x10, 0x18 and 0x1C change neither the latch nor the direction mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized internally |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data or bitmask |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pad_in | input | 32 | Pin levels from the pads |
| pad_out | output | 32 | Values driven onto the pads |
| pad_oe | output | 32 | Per-pin output enable |

## Verification
A wrong latch bit shows on `pad_out` of any output-enabled pin, and on a read of 0x00, in the cycle after the write that caused it. A wrong direction bit shows at once on `pad_oe`, and it also gates or exposes the latch on `pad_out`. A fault in the synchronizer shows as an input read that changes one edge too early or too late. A mask applied to the wrong bits or the wrong alias shows as a difference against the bench's arithmetic model after that single write.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned PINS   = 32;
  localparam int unsigned ADDR_W = 5;

  // word index = byte offset >> 2
  localparam logic [2:0] IDX_DATA = 3'd0;
  localparam logic [2:0] IDX_SET  = 3'd1;
  localparam logic [2:0] IDX_CLR  = 3'd2;
  localparam logic [2:0] IDX_TOG  = 3'd3;
  localparam logic [2:0] IDX_IN   = 3'd4;
  localparam logic [2:0] IDX_DIR  = 3'd5;

  typedef enum logic [2:0] {
    OP_HOLD,
    OP_LOAD,
    OP_SET,
    OP_CLR,
    OP_TOG
  } latch_op_e;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  // synchronizer flops carry no reset
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) stage_q[s] <= async_in;
    end else begin : g_rest
      always_ff @(posedge clk) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  latch_op_e        op,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] q_d;
  logic             q_en;

  always_comb begin
    q_en = (op != OP_HOLD);
    unique case (op)
      OP_LOAD: q_d = wdata;
      OP_SET:  q_d = q | wdata;
      OP_CLR:  q_d = q & ~wdata;
      OP_TOG:  q_d = q ^ wdata;
      default: q_d = q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)   q <= '0;
    else if (q_en) q <= q_d;
  end

  AST_SET_FORCES_ONES: assert property (@(posedge clk) disable iff (!rst_ni)
    (op == OP_SET) |=> ((q & $past(wdata)) == $past(wdata))); // R3
  AST_CLR_FORCES_ZEROS: assert property (@(posedge clk) disable iff (!rst_ni)
    (op == OP_CLR) |=> ((q & $past(wdata)) == '0)); // R4
  AST_TOG_FLIPS_MASK: assert property (@(posedge clk) disable iff (!rst_ni)
    (op == OP_TOG) |=> ((q ^ $past(q)) == $past(wdata))); // R5
  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_ni)
    (op == OP_HOLD) |=> $stable(q)); // R9
endmodule

// File: rtl/gpio_reg_decode.sv
module gpio_reg_decode
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned AW     = 5
) (
  input  logic             wr,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] latch_q,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] in_sync,
  output latch_op_e        op,
  output logic             dir_we,
  output logic [WIDTH-1:0] rdata
);
  logic [2:0] idx;

  assign idx = addr[AW-1:2];

  always_comb begin
    op     = OP_HOLD;
    dir_we = 1'b0;
    if (wr) begin
      unique case (idx)
        IDX_DATA: op     = OP_LOAD;
        IDX_SET:  op     = OP_SET;
        IDX_CLR:  op     = OP_CLR;
        IDX_TOG:  op     = OP_TOG;
        IDX_DIR:  dir_we = 1'b1;
        default:  op     = OP_HOLD;
      endcase
    end
  end

  always_comb begin
    unique case (idx)
      IDX_DATA: rdata = latch_q;
      IDX_IN:   rdata = in_sync;
      IDX_DIR:  rdata = dir_q;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_data_port.sv
module gpio_data_port
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH       = PINS,
  parameter int unsigned AW          = ADDR_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe
);
  logic             rst_ni;
  latch_op_e        op;
  logic             dir_we;
  logic [WIDTH-1:0] latch_q;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] dir_d;
  logic [WIDTH-1:0] in_sync;

  gpio_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ni)
  );

  gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .async_in (pad_in),
    .sync_out (in_sync)
  );

  gpio_reg_decode #(.WIDTH(WIDTH), .AW(AW)) u_dec (
    .wr      (bus_wr),
    .addr    (bus_addr),
    .latch_q (latch_q),
    .dir_q   (dir_q),
    .in_sync (in_sync),
    .op      (op),
    .dir_we  (dir_we),
    .rdata   (bus_rdata)
  );

  gpio_out_latch #(.WIDTH(WIDTH)) u_latch (
    .clk    (clk),
    .rst_ni (rst_ni),
    .op     (op),
    .wdata  (bus_wdata),
    .q      (latch_q)
  );

  // direction mask: next state and register kept apart
  always_comb begin
    dir_d = dir_we ? bus_wdata : dir_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     dir_q <= '0;
    else if (dir_we) dir_q <= dir_d;
  end

  assign pad_oe  = dir_q;
  assign pad_out = latch_q & dir_q;

  AST_DIR_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_ni)
    !(bus_wr && (bus_addr[AW-1:2] == IDX_DIR)) |=> $stable(pad_oe)); // R7
  AST_NO_DRIVE_WHEN_INPUT: assert property (@(posedge clk) disable iff (!rst_ni)
    (pad_out & ~pad_oe) == '0); // R8
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_ni |-> (pad_oe == '0 && pad_out == '0)); // R1
endmodule

// File: tb/tb_gpio_data_port.sv
module tb_gpio_data_port;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in;
  logic [31:0] pad_out;
  logic [31:0] pad_oe;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  logic [31:0] m_out = '0;
  logic [31:0] m_dir = '0;
  logic [31:0] seed  = 32'h1ace_b00c;

  always #10 clk = ~clk;  // 50 MHz

  gpio_data_port dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  function automatic logic [31:0] next_rand(input logic [31:0] x);
    logic [31:0] y = x;
    y ^= y << 13;
    y ^= y >> 17;
    y ^= y << 5;
    return y;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    case (a[4:2])
      3'd0: m_out = d;
      3'd1: m_out = m_out | d;
      3'd2: m_out = m_out & ~d;
      3'd3: m_out = m_out ^ d;
      3'd5: m_dir = d;
      default: ;
    endcase
  endtask

  task automatic read_chk(input string req, input logic [4:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic pads_chk(input string req);
    check(req, pad_oe, m_dir);
    check(req, pad_out, m_out & m_dir);
  endtask

  initial begin
    bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; pad_in = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", pad_oe, 32'h0);
    check("R1", pad_out, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    read_chk("R1", 5'h00, 32'h0);
    read_chk("R1", 5'h14, 32'h0);
    pads_chk("R1");

    // R7 and R8: full drive, then walking direction bits
    write(5'h14, 32'hffff_ffff);
    write(5'h00, 32'ha5a5_5a5a);
    read_chk("R2", 5'h00, m_out);
    pads_chk("R8");
    for (int i = 0; i < 32; i++) begin
      write(5'h14, 32'h1 << i);
      read_chk("R7", 5'h14, m_dir);
      pads_chk("R8");
    end
    write(5'h14, 32'hffff_ffff);

    // R3, R4, R5: walking single-bit masks on each alias
    for (int i = 0; i < 32; i++) begin
      write(5'h04, 32'h1 << i); read_chk("R3", 5'h00, m_out); pads_chk("R3");
      write(5'h08, 32'h1 << i); read_chk("R4", 5'h00, m_out); pads_chk("R4");
      write(5'h0c, 32'h1 << i); read_chk("R5", 5'h00, m_out); pads_chk("R5");
    end

    // pseudo-random sweep over all offsets (includes ignored ones, R9)
    for (int n = 0; n < 600; n++) begin
      logic [4:0] a;
      seed = next_rand(seed);
      a = {seed[2:0], 2'b00};
      write(a, next_rand(seed ^ 32'h5555_aaaa));
      read_chk(a == 5'h14 ? "R7" : "R2", 5'h00, m_out);
      read_chk("R7", 5'h14, m_dir);
      pads_chk("R8");
    end

    // R9: alias and unused reads return zero; ignored writes
    write(5'h00, 32'h1234_5678);
    write(5'h14, 32'h0f0f_f0f0);
    read_chk("R9", 5'h04, 32'h0);
    read_chk("R9", 5'h08, 32'h0);
    read_chk("R9", 5'h0c, 32'h0);
    read_chk("R9", 5'h18, 32'h0);
    read_chk("R9", 5'h1c, 32'h0);
    write(5'h10, 32'hdead_beef);
    write(5'h18, 32'hdead_beef);
    write(5'h1c, 32'hdead_beef);
    read_chk("R9", 5'h00, 32'h1234_5678);
    read_chk("R9", 5'h14, 32'h0f0f_f0f0);
    pads_chk("R9");

    // R6: two-edge input latency
    for (int n = 0; n < 40; n++) begin
      logic [31:0] prev, nv;
      @(negedge clk);
      pad_in = 32'h0; repeat (3) @(negedge clk);
      prev = pad_in;
      seed = next_rand(seed);
      nv = (n < 32) ? (32'h1 << n) : seed;
      pad_in = nv;
      @(negedge clk);
      read_chk("R6", 5'h10, prev);
      @(negedge clk);
      read_chk("R6", 5'h10, nv);
    end

    // R1: reset mid-run clears state
    rst_n = 1'b0;
    @(negedge clk);
    m_out = '0; m_dir = '0;
    pads_chk("R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    read_chk("R1", 5'h00, 32'h0);
    read_chk("R1", 5'h14, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule